// File: doc/BRIEF.md
# Ones' Complement Adder-Subtractor

This unit adds or subtracts two signed operands held in ones' complement form and hands back a registered result together with a signed overflow flag. In this encoding a value is negated by flipping all of its bits, so subtraction is performed by inverting the second operand and then adding. Any carry that leaves the top bit of the sum is wrapped around and added back in at the least significant bit. This end-around carry is what makes the arithmetic correct when the encoding has two zeros: all-zeros is +0 and all-ones is -0.

A caller presents the operands, the operation select and a zero-fold control together with `valid_in`. One clock later the result and the overflow flag appear, marked by `valid_out`. When `norm_zero` is high, a result of -0 is replaced by +0 before it is registered. The operand width is set by the parameter `N`, which defaults to 8.

Top module: `oc_addsub`

## Requirements
- R1: With `op_sub` = 0, `result` equals the ones' complement sum of `a` and `b`. This is the N-bit sum with any carry out of bit N-1 added back in at bit 0.
- R2: With `op_sub` = 1, `result` equals `a` plus the bitwise inverse of `b`, with the same end-around carry.
- R3: A carry out of the top bit is always added back in. For example, with N=8, 0xFE + 0x03 gives 0x02, and 0x05 - 0x02 gives 0x03.
- R4: With `norm_zero` = 1, an all-ones result is delivered as all-zeros. With `norm_zero` = 0, an all-ones result is delivered unchanged. For example, 0x05 - 0x05 gives 0x00 or 0xFF depending on `norm_zero`.
- R5: `overflow` is 1 exactly when the two adder inputs (`a` and the possibly inverted `b`) have equal bit N-1 and the result before zero folding has a different bit N-1. Operands of differing sign never overflow.
- R6: `valid_out` is 1 in the cycle after a clock edge that sampled `valid_in` = 1, and 0 in the cycle after one that sampled `valid_in` = 0.
- R7: When `valid_in` is 0, `result` and `overflow` keep their previous values, whatever values the other inputs carry.
- R8: While `rst` is high, a clock edge clears `result`, `overflow` and `valid_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and controls are valid |
| op_sub | input | 1 | 0 selects add, 1 selects subtract (a - b) |
| norm_zero | input | 1 | Fold a -0 result to +0 |
| a | input | N | First operand, ones' complement |
| b | input | N | Second operand, ones' complement |
| result | output | N | Registered result |
| overflow | output | 1 | Registered signed overflow flag |
| valid_out | output | 1 | Result and flag are valid |

## Verification
Every result, overflow flag and valid strobe is due exactly one clock edge after the edge that samples `valid_in`. There is only one register between the inputs and the outputs. The bench drives its inputs on the falling edge and checks the outputs shortly after the next rising edge, so each check looks at the outcome of the transaction just issued. For hold and idle cycles, the bench drives `valid_in` low with fresh junk on the operands and confirms, after that same edge, that the outputs still show the previous transaction.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    OC_ADD = 1'b0,
    OC_SUB = 1'b1
  } oc_op_e;
endpackage

// File: rtl/oc_cond_invert.sv
module oc_cond_invert #(
  parameter int N = 8
) (
  input  logic         inv,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign dout[i] = din[i] ^ inv;
  end
endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] sum,
  output logic         ovf
);
  localparam int TOP = N - 1;

  logic [N:0] raw;

  always_comb begin
    raw = {1'b0, x} + {1'b0, y};
    // The wrapped carry can never ripple out a second time.
    sum = raw[N-1:0] + {{(N-1){1'b0}}, raw[N]};
    ovf = (x[TOP] == y[TOP]) && (sum[TOP] != x[TOP]);
  end
endmodule

// File: rtl/oc_zero_fold.sv
module oc_zero_fold #(
  parameter int N = 8
) (
  input  logic         enable,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  always_comb begin
    if (enable && (&din)) dout = '0;
    else                  dout = din;
  end
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
  import oc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic         op_sub,
  input  logic         norm_zero,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] result,
  output logic         overflow,
  output logic         valid_out
);
  localparam int TOP = N - 1;

  oc_op_e       op;
  logic [N-1:0] b_eff;
  logic [N-1:0] raw_sum;
  logic         raw_ovf;
  logic [N-1:0] folded;

  assign op = oc_op_e'(op_sub);

  oc_cond_invert #(.N(N)) u_inv (
    .inv  (op == OC_SUB),
    .din  (b),
    .dout (b_eff)
  );

  oc_eac_adder #(.N(N)) u_add (
    .x   (a),
    .y   (b_eff),
    .sum (raw_sum),
    .ovf (raw_ovf)
  );

  oc_zero_fold #(.N(N)) u_fold (
    .enable (norm_zero),
    .din    (raw_sum),
    .dout   (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      overflow  <= 1'b0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result   <= folded;
        overflow <= raw_ovf;
      end
    end
  end

  // R6: valid strobe follows valid_in by one edge
  a_r6_valid_rise: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  a_r6_valid_low: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  // R7: idle cycles leave the outputs untouched
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(result) && $stable(overflow)));

  // R4: folding never lets -0 out
  a_r4_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_in && norm_zero) |=> (result != {N{1'b1}}));

  // R5: operands of differing effective sign cannot overflow
  a_r5_add_mixed: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !op_sub && (a[TOP] != b[TOP])) |=> !overflow);
  a_r5_sub_alike: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_sub && (a[TOP] == b[TOP])) |=> !overflow);
endmodule

// File: tb/oc_addsub_tb.sv
`timescale 1ns/1ps
module oc_addsub_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_in = 1'b0;
  logic         op_sub = 1'b0;
  logic         norm_zero = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [N-1:0] result;
  logic         overflow;
  logic         valid_out;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] last_res = '0;
  logic         last_ovf = 1'b0;

  always #2.5 clk = ~clk;

  oc_addsub #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_sub(op_sub),
    .norm_zero(norm_zero), .a(a), .b(b),
    .result(result), .overflow(overflow), .valid_out(valid_out)
  );

  // Returns {overflow, result} as the requirements define them.
  function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y,
                                       input logic sub, input logic nz);
    logic [N-1:0] ye, s;
    logic [N:0]   w;
    logic         ov;
    ye = sub ? ~y : y;
    w  = {1'b0, x} + {1'b0, ye};
    s  = w[N-1:0];
    if (w[N]) s = s + 1'b1;
    ov = (x[N-1] == ye[N-1]) && (s[N-1] != x[N-1]);
    if (nz && (s == {N{1'b1}})) s = '0;
    return {ov, s};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [N-1:0] x, input logic [N-1:0] y,
                        input logic sub, input logic nz);
    logic [N:0] e;
    @(negedge clk);
    valid_in = 1'b1; a = x; b = y; op_sub = sub; norm_zero = nz;
    e = model(x, y, sub, nz);
    @(posedge clk); #1;
    check({req, " result"}, result, e[N-1:0]);
    check({req, " overflow"}, {{(N-1){1'b0}}, overflow}, {{(N-1){1'b0}}, e[N]});
    check("R6 valid_out high", {{(N-1){1'b0}}, valid_out}, {{(N-1){1'b0}}, 1'b1});
    last_res = e[N-1:0];
    last_ovf = e[N];
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    valid_in = 1'b0; a = N'($urandom); b = N'($urandom);
    op_sub = 1'($urandom); norm_zero = 1'($urandom);
    @(posedge clk); #1;
    check("R7 hold result", result, last_res);
    check("R7 hold overflow", {{(N-1){1'b0}}, overflow}, {{(N-1){1'b0}}, last_ovf});
    check("R6 valid_out low", {{(N-1){1'b0}}, valid_out}, '0);
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    valid_in = 1'b1; a = 8'h11; b = 8'h22;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset result", result, '0);
    check("R8 reset overflow", {{(N-1){1'b0}}, overflow}, '0);
    check("R8 reset valid_out", {{(N-1){1'b0}}, valid_out}, '0);
    @(negedge clk);
    rst = 1'b0; valid_in = 1'b0;

    // Directed corner cases (expected values written out)
    run_op("R1 3+4", 8'h03, 8'h04, 1'b0, 1'b0);   check("R1 literal", result, 8'h07);
    run_op("R3 -1+3", 8'hFE, 8'h03, 1'b0, 1'b0);  check("R3 literal", result, 8'h02);
    run_op("R2 5-2", 8'h05, 8'h02, 1'b1, 1'b0);   check("R2 literal", result, 8'h03);
    run_op("R4 5-5 keep", 8'h05, 8'h05, 1'b1, 1'b0); check("R4 keep -0", result, 8'hFF);
    run_op("R4 5-5 fold", 8'h05, 8'h05, 1'b1, 1'b1); check("R4 fold -0", result, 8'h00);
    run_op("R5 pos ovf", 8'h7F, 8'h01, 1'b0, 1'b0);
    check("R5 literal", {{(N-1){1'b0}}, overflow}, 8'h01);
    run_op("R5 neg ovf", 8'h80, 8'h01, 1'b1, 1'b0);
    run_op("R5 mixed", 8'h7F, 8'h80, 1'b0, 1'b0);
    run_op("R3 -0 + -0", 8'hFF, 8'hFF, 1'b0, 1'b0);
    run_op("R1 +0 + -0", 8'h00, 8'hFF, 1'b0, 1'b1);
    idle_cycle();
    idle_cycle();

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] x, y;
      x = N'($urandom);
      y = N'($urandom);
      if (i % 7 == 0) y = (i % 2 == 0) ? x : ~x;
      run_op($urandom_range(0, 1) ? "R1 random" : "R2 random", x, y,
             1'($urandom), 1'($urandom));
      if (i % 9 == 0) idle_cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule